// File: doc/BRIEF.md
# Shader Attribute-Load Field Decoder

This block turns the raw fields of a shader attribute-load instruction into what the load unit needs. It produces an addressing mode, a byte address aligned to the access size, a destination register index aligned the same way, and an element count. It also raises a set of independent legality flags. The addressing mode is not carried by an opcode bit. It is inferred from three things: whether the index register is the zero register, the patch bit, and whether the immediate is zero.

The decode is pure logic. A parameter, `OUT_REG`, selects whether one register stage sits in front of the outputs. With the default `OUT_REG = 1`, every output reflects the inputs presented one clock edge earlier. The block does not read attribute storage and does not resolve attribute maps. When physical indexing is used, the index register already holds the translated address.

Top module: `attr_load_decoder`

## Requirements
- R1: When `idx_is_zero` is 1, `mode_code` is 2'b00 (immediate). The address is `imm_field[9:0]` zero-extended, and `idx_val` has no effect on any output.
- R2: When `idx_is_zero` is 0, `patch_sel` is 0 and `imm_field` is zero, `mode_code` is 2'b10 (physical indexed) and the address is `idx_val`.
- R3: When `idx_is_zero` is 0 and `patch_sel` is 1, `mode_code` is 2'b01 (patch indexed). The address is `idx_val` plus the sign-extended 11-bit `imm_field`, modulo 2^32.
- R4: When `idx_is_zero` is 0, `patch_sel` is 0 and `imm_field` is nonzero, the encoding is malformed. `mode_code` is 2'b11, `err_mode` is 1, and the address is `idx_val`.
- R5: `attr_addr` is the address from R1 to R4 with low bits cleared, depending on `size_code`:
  - code 0 (32 bits) clears 2 bits;
  - code 1 (64 bits) clears 3 bits;
  - codes 2 and 3 (96 and 128 bits) clear 4 bits.
- R6: `dst_reg_aligned` is `dst_reg` with low bits cleared. Code 0 clears none, code 1 clears bit 0, and codes 2 and 3 clear bits 1:0.
- R7: `elem_count` equals `size_code + 1`.
- R8: `err_phys_vec` is 1 exactly when the mode is physical indexed and `size_code` is not 0.
- R9: `err_vtx_handle` is 1 exactly when `stage_code` is 0 or 1 (the two vertex variants) and `vtx_is_zero` is 0.
- R10: `err_out_stage` is 1 exactly when `sel_out_buf` is 1 and `stage_code` is above 3. Codes 0 to 3 are the two vertex variants, tessellation control and tessellation evaluation.
- R11: `err_no_handle` is 1 exactly when `stage_code` is 2, 3 or 4 (tessellation control, tessellation evaluation, geometry) and `vtx_is_zero` is 1.
- R12: Each flag depends only on its own condition. `dec_valid` is 1 exactly when all five flags are 0.
- R13: With `OUT_REG = 1`, every output follows the inputs from the previous rising clock edge. `out_buf` copies `sel_out_buf` and `patch_space` copies `patch_sel`. While `rst_n` is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_out_buf | input | 1 | 1 selects the output buffer, 0 the input buffer |
| patch_sel | input | 1 | Patch attribute space |
| size_code | input | 2 | Access size: 0=32, 1=64, 2=96, 3=128 bits |
| idx_is_zero | input | 1 | Index register is the zero register |
| idx_val | input | DATA_W | Index register value |
| imm_field | input | IMM_W | Immediate field |
| vtx_is_zero | input | 1 | Vertex-handle register is the zero register |
| stage_code | input | 3 | Shader stage: 0,1 vertex; 2 tess control; 3 tess eval; 4 geometry; 5-7 other |
| dst_reg | input | REG_W | Destination register index |
| mode_code | output | 2 | 00 immediate, 01 patch indexed, 10 physical, 11 malformed |
| attr_addr | output | DATA_W | Aligned byte address |
| dst_reg_aligned | output | REG_W | Aligned destination register index |
| elem_count | output | 3 | Number of attribute words (1 to 4) |
| out_buf | output | 1 | Buffer select, passed on |
| patch_space | output | 1 | Patch space, passed on |
| err_mode | output | 1 | Malformed indexed encoding |
| err_phys_vec | output | 1 | Vector access in physical mode |
| err_vtx_handle | output | 1 | Vertex stage supplied a vertex handle |
| err_out_stage | output | 1 | Output buffer selected by a stage that may not use it |
| err_no_handle | output | 1 | Geometry or tessellation stage without a vertex handle |
| dec_valid | output | 1 | No flag set |

## Verification
The block keeps no state beyond the output register. Any wrong decode therefore shows up at the ports on the edge right after the inputs are applied, in exactly one vector. An error on the mode-inference path shows as a wrong `mode_code` together with an address built from the wrong operands. An error on an alignment path leaves low address bits or register bits set. An error in the legality logic turns a flag on or off in the vector that hits its stage, size or handle combination. The sweep covers every combination of the control inputs against boundary immediates, so each of these errors is seen within one cycle of the vector that triggers it.

// File: rtl/ald_pkg.sv
package ald_pkg;

  typedef enum logic [1:0] {
    MODE_IMM   = 2'b00,
    MODE_PATCH = 2'b01,
    MODE_PHYS  = 2'b10,
    MODE_BAD   = 2'b11
  } ald_mode_e;

  localparam logic [2:0] STG_VTX_A    = 3'd0;
  localparam logic [2:0] STG_VTX_B    = 3'd1;
  localparam logic [2:0] STG_TESS_CTL = 3'd2;
  localparam logic [2:0] STG_TESS_EVL = 3'd3;
  localparam logic [2:0] STG_GEOM     = 3'd4;

  // number of low address bits cleared for a size code
  function automatic logic [2:0] addr_drop_bits(input logic [1:0] sz);
    case (sz)
      2'd0:    addr_drop_bits = 3'd2;
      2'd1:    addr_drop_bits = 3'd3;
      default: addr_drop_bits = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ald_addr_gen.sv
module ald_addr_gen
  import ald_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 11
) (
  input  logic              patch_sel,
  input  logic              idx_is_zero,
  input  logic [DATA_W-1:0] idx_val,
  input  logic [IMM_W-1:0]  imm_field,
  output ald_mode_e         mode,
  output logic [DATA_W-1:0] raw_addr
);

  localparam int UIMM_W = IMM_W - 1;

  logic [DATA_W-1:0] imm_unsigned;
  logic [DATA_W-1:0] imm_signed;
  logic              imm_zero;

  assign imm_unsigned = {{(DATA_W-UIMM_W){1'b0}}, imm_field[UIMM_W-1:0]};
  assign imm_signed   = {{(DATA_W-IMM_W){imm_field[IMM_W-1]}}, imm_field};
  assign imm_zero     = (imm_field == '0);

  always_comb begin
    if (idx_is_zero) begin
      mode     = MODE_IMM;
      raw_addr = imm_unsigned;
    end else if (patch_sel) begin
      mode     = MODE_PATCH;
      raw_addr = idx_val + imm_signed;
    end else if (imm_zero) begin
      mode     = MODE_PHYS;
      raw_addr = idx_val;
    end else begin
      mode     = MODE_BAD;
      raw_addr = idx_val;
    end
  end

endmodule

// File: rtl/ald_align.sv
module ald_align
  import ald_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 8
) (
  input  logic [1:0]        size_code,
  input  logic [DATA_W-1:0] raw_addr,
  input  logic [REG_W-1:0]  dst_reg,
  output logic [DATA_W-1:0] attr_addr,
  output logic [REG_W-1:0]  dst_aligned,
  output logic [2:0]        elem_count
);

  logic [DATA_W-1:0] low_mask;

  assign low_mask   = (DATA_W'(1) << addr_drop_bits(size_code)) - DATA_W'(1);
  assign attr_addr  = raw_addr & ~low_mask;
  assign elem_count = {1'b0, size_code} + 3'd1;

  always_comb begin
    case (size_code)
      2'd0:    dst_aligned = dst_reg;
      2'd1:    dst_aligned = {dst_reg[REG_W-1:1], 1'b0};
      default: dst_aligned = {dst_reg[REG_W-1:2], 2'b00};
    endcase
  end

endmodule

// File: rtl/ald_legality.sv
module ald_legality
  import ald_pkg::*;
(
  input  logic       sel_out_buf,
  input  logic [1:0] size_code,
  input  ald_mode_e  mode,
  input  logic [2:0] stage_code,
  input  logic       vtx_is_zero,
  output logic       err_mode,
  output logic       err_phys_vec,
  output logic       err_vtx_handle,
  output logic       err_out_stage,
  output logic       err_no_handle,
  output logic       dec_valid
);

  logic is_vertex;
  logic needs_handle;

  assign is_vertex    = (stage_code == STG_VTX_A) || (stage_code == STG_VTX_B);
  assign needs_handle = (stage_code == STG_TESS_CTL) || (stage_code == STG_TESS_EVL) ||
                        (stage_code == STG_GEOM);

  assign err_mode       = (mode == MODE_BAD);
  assign err_phys_vec   = (mode == MODE_PHYS) && (size_code != 2'd0);
  assign err_vtx_handle = is_vertex && !vtx_is_zero;
  assign err_out_stage  = sel_out_buf && (stage_code > STG_TESS_EVL);
  assign err_no_handle  = needs_handle && vtx_is_zero;
  assign dec_valid      = !(err_mode || err_phys_vec || err_vtx_handle ||
                            err_out_stage || err_no_handle);

endmodule

// File: rtl/attr_load_decoder.sv
module attr_load_decoder
  import ald_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 11,
  parameter int REG_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_out_buf,
  input  logic              patch_sel,
  input  logic [1:0]        size_code,
  input  logic              idx_is_zero,
  input  logic [DATA_W-1:0] idx_val,
  input  logic [IMM_W-1:0]  imm_field,
  input  logic              vtx_is_zero,
  input  logic [2:0]        stage_code,
  input  logic [REG_W-1:0]  dst_reg,
  output logic [1:0]        mode_code,
  output logic [DATA_W-1:0] attr_addr,
  output logic [REG_W-1:0]  dst_reg_aligned,
  output logic [2:0]        elem_count,
  output logic              out_buf,
  output logic              patch_space,
  output logic              err_mode,
  output logic              err_phys_vec,
  output logic              err_vtx_handle,
  output logic              err_out_stage,
  output logic              err_no_handle,
  output logic              dec_valid
);

  localparam int PACK_W = 2 + DATA_W + REG_W + 3 + 2 + 6;

  ald_mode_e         mode_d;
  logic [DATA_W-1:0] raw_addr_d;
  logic [DATA_W-1:0] addr_d;
  logic [REG_W-1:0]  dst_d;
  logic [2:0]        cnt_d;
  logic [5:0]        flags_d;
  logic [PACK_W-1:0] pack_d;
  logic [PACK_W-1:0] pack_q;

  ald_addr_gen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) addr_gen_i (
    .patch_sel   (patch_sel),
    .idx_is_zero (idx_is_zero),
    .idx_val     (idx_val),
    .imm_field   (imm_field),
    .mode        (mode_d),
    .raw_addr    (raw_addr_d)
  );

  ald_align #(.DATA_W(DATA_W), .REG_W(REG_W)) align_i (
    .size_code   (size_code),
    .raw_addr    (raw_addr_d),
    .dst_reg     (dst_reg),
    .attr_addr   (addr_d),
    .dst_aligned (dst_d),
    .elem_count  (cnt_d)
  );

  ald_legality legal_i (
    .sel_out_buf    (sel_out_buf),
    .size_code      (size_code),
    .mode           (mode_d),
    .stage_code     (stage_code),
    .vtx_is_zero    (vtx_is_zero),
    .err_mode       (flags_d[5]),
    .err_phys_vec   (flags_d[4]),
    .err_vtx_handle (flags_d[3]),
    .err_out_stage  (flags_d[2]),
    .err_no_handle  (flags_d[1]),
    .dec_valid      (flags_d[0])
  );

  assign pack_d = {mode_d, addr_d, dst_d, cnt_d, sel_out_buf, patch_sel, flags_d};

  generate
    if (OUT_REG) begin : g_reg
      logic [PACK_W-1:0] pack_nxt;
      logic              pack_en;

      assign pack_en = 1'b1;

      always_comb begin
        pack_nxt = pack_q;
        if (pack_en) pack_nxt = pack_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pack_q <= '0;
        else        pack_q <= pack_nxt;
      end
    end else begin : g_comb
      assign pack_q = pack_d;
    end
  endgenerate

  assign {mode_code, attr_addr, dst_reg_aligned, elem_count, out_buf, patch_space,
          err_mode, err_phys_vec, err_vtx_handle, err_out_stage, err_no_handle,
          dec_valid} = pack_q;

endmodule

// File: rtl/attr_load_decoder_chk.sv
module attr_load_decoder_chk #(
  parameter int DATA_W  = 32,
  parameter int REG_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        stage_code,
  input logic              vtx_is_zero,
  input logic [1:0]        mode_code,
  input logic [DATA_W-1:0] attr_addr,
  input logic [REG_W-1:0]  dst_reg_aligned,
  input logic [2:0]        elem_count,
  input logic              err_mode,
  input logic              err_phys_vec,
  input logic              err_vtx_handle,
  input logic              err_out_stage,
  input logic              err_no_handle,
  input logic              dec_valid
);

  p_imm_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b00) |-> (attr_addr[DATA_W-1:10] == '0));

  p_bad_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b11) |-> err_mode);

  p_align32_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_count == 3'd1) |-> (attr_addr[1:0] == 2'b00));

  p_align64_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_count == 3'd2) |-> (attr_addr[2:0] == 3'b000));

  p_align128_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_count >= 3'd3) |-> (attr_addr[3:0] == 4'b0000));

  p_reg_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_count >= 3'd3) |-> (dst_reg_aligned[1:0] == 2'b00));

  p_phys_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_code == 2'b10) && (elem_count > 3'd1)) |-> err_phys_vec);

  p_valid_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !(err_mode || err_phys_vec || err_vtx_handle || err_out_stage || err_no_handle));

  generate
    if (OUT_REG) begin : g_seq
      p_vtx_handle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((stage_code < 3'd2) && !vtx_is_zero) |=> err_vtx_handle);
    end else begin : g_cmb
      p_vtx_handle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((stage_code < 3'd2) && !vtx_is_zero) |-> err_vtx_handle);
    end
  endgenerate

endmodule

bind attr_load_decoder attr_load_decoder_chk #(
  .DATA_W(DATA_W), .REG_W(REG_W), .OUT_REG(OUT_REG)
) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .stage_code      (stage_code),
  .vtx_is_zero     (vtx_is_zero),
  .mode_code       (mode_code),
  .attr_addr       (attr_addr),
  .dst_reg_aligned (dst_reg_aligned),
  .elem_count      (elem_count),
  .err_mode        (err_mode),
  .err_phys_vec    (err_phys_vec),
  .err_vtx_handle  (err_vtx_handle),
  .err_out_stage   (err_out_stage),
  .err_no_handle   (err_no_handle),
  .dec_valid       (dec_valid)
);

// File: tb/attr_load_decoder_tb_top.sv
`timescale 1ns/1ps
module attr_load_decoder_tb_top;

  localparam int DW = 32;
  localparam int IW = 11;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_out_buf = 1'b0, patch_sel = 1'b0, idx_is_zero = 1'b1, vtx_is_zero = 1'b1;
  logic [1:0]    size_code = '0;
  logic [DW-1:0] idx_val = '0;
  logic [IW-1:0] imm_field = '0;
  logic [2:0]    stage_code = '0;
  logic [RW-1:0] dst_reg = '0;

  logic [1:0]    mode_code;
  logic [DW-1:0] attr_addr;
  logic [RW-1:0] dst_reg_aligned;
  logic [2:0]    elem_count;
  logic          out_buf, patch_space, err_mode, err_phys_vec, err_vtx_handle;
  logic          err_out_stage, err_no_handle, dec_valid;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  attr_load_decoder #(.DATA_W(DW), .IMM_W(IW), .REG_W(RW), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_out_buf(sel_out_buf), .patch_sel(patch_sel),
    .size_code(size_code), .idx_is_zero(idx_is_zero), .idx_val(idx_val),
    .imm_field(imm_field), .vtx_is_zero(vtx_is_zero), .stage_code(stage_code),
    .dst_reg(dst_reg), .mode_code(mode_code), .attr_addr(attr_addr),
    .dst_reg_aligned(dst_reg_aligned), .elem_count(elem_count), .out_buf(out_buf),
    .patch_space(patch_space), .err_mode(err_mode), .err_phys_vec(err_phys_vec),
    .err_vtx_handle(err_vtx_handle), .err_out_stage(err_out_stage),
    .err_no_handle(err_no_handle), .dec_valid(dec_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin : stim
    logic [DW-1:0] imm_set [5];
    logic [DW-1:0] idx_set [3];
    logic [RW-1:0] reg_set [2];
    imm_set[0] = 32'h000; imm_set[1] = 32'h2A7; imm_set[2] = 32'h013;
    imm_set[3] = 32'h400; imm_set[4] = 32'h7FF;
    idx_set[0] = 32'h0000_0100; idx_set[1] = 32'h0000_0003; idx_set[2] = 32'hFFFF_FFF0;
    reg_set[0] = 8'hFF; reg_set[1] = 8'h37;

    // reset state, R13
    #3;
    chk({mode_code, attr_addr, dst_reg_aligned, elem_count, out_buf, patch_space,
         err_mode, err_phys_vec, err_vtx_handle, err_out_stage, err_no_handle, dec_valid} == '0,
        "R13 reset", {63'd0, dec_valid}, 64'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    for (int so = 0; so < 2; so++)
    for (int pa = 0; pa < 2; pa++)
    for (int sz = 0; sz < 4; sz++)
    for (int iz = 0; iz < 2; iz++)
    for (int st = 0; st < 8; st++)
    for (int vz = 0; vz < 2; vz++)
    for (int im = 0; im < 5; im++)
    for (int ix = 0; ix < 3; ix++)
    for (int rg = 0; rg < 2; rg++) begin
      logic [1:0]    e_mode;
      logic [DW-1:0] e_raw, e_addr, sx;
      logic [RW-1:0] e_reg;
      logic          e_em, e_pv, e_vh, e_os, e_nh, e_ok;
      string         mtag;
      @(negedge clk);
      sel_out_buf = so[0]; patch_sel = pa[0]; size_code = sz[1:0];
      idx_is_zero = iz[0]; stage_code = st[2:0]; vtx_is_zero = vz[0];
      imm_field = imm_set[im][IW-1:0]; idx_val = idx_set[ix]; dst_reg = reg_set[rg];

      sx = imm_set[im][10] ? (imm_set[im] | 32'hFFFF_F800) : imm_set[im];
      if (iz == 1) begin
        e_mode = 2'b00; e_raw = imm_set[im] % 1024; mtag = "R1";
      end else if (pa == 1) begin
        e_mode = 2'b01; e_raw = idx_set[ix] + sx; mtag = "R3";
      end else if (imm_set[im] == 0) begin
        e_mode = 2'b10; e_raw = idx_set[ix]; mtag = "R2";
      end else begin
        e_mode = 2'b11; e_raw = idx_set[ix]; mtag = "R4";
      end
      e_addr = e_raw - (e_raw % (32'd1 << (sz == 0 ? 2 : (sz == 1 ? 3 : 4))));
      e_reg  = reg_set[rg] - (reg_set[rg] % (8'd1 << (sz == 0 ? 0 : (sz == 1 ? 1 : 2))));
      e_em = (e_mode == 2'b11);
      e_pv = (e_mode == 2'b10) && (sz != 0);
      e_vh = (st < 2) && (vz == 0);
      e_os = (so == 1) && (st > 3);
      e_nh = (st >= 2) && (st <= 4) && (vz == 1);
      e_ok = !(e_em || e_pv || e_vh || e_os || e_nh);

      @(posedge clk); #1;
      chk(mode_code == e_mode, {mtag, " mode"}, 64'(mode_code), 64'(e_mode));
      chk(attr_addr == e_addr, {mtag, " R5 addr"}, 64'(attr_addr), 64'(e_addr));
      chk(dst_reg_aligned == e_reg, "R6 reg", 64'(dst_reg_aligned), 64'(e_reg));
      chk(elem_count == 3'(sz + 1), "R7 count", 64'(elem_count), 64'(sz + 1));
      chk(err_mode == e_em, "R4 err_mode", 64'(err_mode), 64'(e_em));
      chk(err_phys_vec == e_pv, "R8 phys_vec", 64'(err_phys_vec), 64'(e_pv));
      chk(err_vtx_handle == e_vh, "R9 vtx_handle", 64'(err_vtx_handle), 64'(e_vh));
      chk(err_out_stage == e_os, "R10 out_stage", 64'(err_out_stage), 64'(e_os));
      chk(err_no_handle == e_nh, "R11 no_handle", 64'(err_no_handle), 64'(e_nh));
      chk(dec_valid == e_ok, "R12 valid", 64'(dec_valid), 64'(e_ok));
      chk({out_buf, patch_space} == {so[0], pa[0]}, "R13 pass", 64'({out_buf, patch_space}),
          64'({so[0], pa[0]}));
    end

    // R13: asynchronous reset clears outputs mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(elem_count == 3'd0 && attr_addr == '0 && !dec_valid, "R13 async reset",
        64'(elem_count), 64'd0);
    finish_run();
  end

endmodule